// File: doc/BRIEF.md
# Bootstrap Memory Copy Engine

This block holds a small boot image in a memory that stays powered while the rest of the subsystem sleeps. On command it copies a run of 32-bit words out of that memory into a separate instruction memory. A host reaches the block through a simple register port. It loads the boot image through a memory window, then programs a source word index, a destination word address and a word count.

There are two ways to start a copy. The host can set the start bit in the control register; that bit clears itself when the copy ends, so the host can poll it. Once the host has set the arm bit, every power-up event also starts the configured copy without any host action. The boot image is not lost across power-up events, so every automatic copy writes the same words. The instruction memory sits outside the block and is written through a one-word write port.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset the control register (offset 0x000) and the status register (offset 0x010) read 0, and the instruction memory port does not write.
- R2: Host byte offsets 0x400 to 0x7FC address the 256-word boot memory; word i sits at 0x400 + 4*i. Writes store the word, and a read returns it on host_rdata in the cycle after host_rd.
- R3: The source index (0x004, bits 7:0), destination address (0x008, bits 11:0) and count (0x00C, bits 8:0) read back as written, with the upper bits 0. A read of any other offset below 0x400 returns 0, and all register reads have one cycle of latency.
- R4: Writing control bit 31 as 1 while idle starts a copy. Bit 31 reads 1 while the copy runs and 0 once it has finished.
- R5: A copy of N words writes boot word (src+k) mod 256 to instruction address dst+k for k = 0 to N-1, in increasing k. There is exactly one write every two clocks, and the count of writes is exactly N.
- R6: Status bit 0 is cleared when a copy with a nonzero count starts and set when the copy completes.
- R7: A start with count 0 writes nothing and ends at once: control bit 31 reads 0 and status bit 0 reads 1.
- R8: While a copy runs, writes to the source, destination and count registers are ignored, and so is a further start request. The copy completes with its original settings, and the registers keep their old values.
- R9: Control bit 30 is a readable arm bit. While it is 1 and the block is idle, a pulse on pwr_up starts the configured copy. While it is 0, pwr_up does nothing.
- R10: Boot memory contents survive power-up events, so repeated automatic copies produce identical writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 11 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after host_rd |
| pwr_up | input | 1 | Power-up event pulse |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | 12 | Instruction memory word address |
| imem_wdata | output | 32 | Instruction memory write data |

## Verification
A wrong copy pointer, or a count that is off by one, shows up on the instruction write port at the first wrong word. The scoreboard checks the address, the data and the two-clock spacing of every write as it happens. A start or busy flag that is stuck, or that clears too early, shows on the control readback within a few clocks, and it also shows as missing or extra writes when the copy ends. Configuration that changes during a copy, or a power-up event that starts a copy it should not, shows as writes the scoreboard did not expect, or as a wrong register readback straight after the stimulus.

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
  parameter int BMEM_WORDS = 256,
  parameter int DST_AW = 12,
  localparam int SAW = $clog2(BMEM_WORDS),
  localparam int CW = SAW + 1,
  localparam int HAW = SAW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [HAW-1:0]    host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              pwr_up,
  output logic              imem_we,
  output logic [DST_AW-1:0] imem_addr,
  output logic [31:0]       imem_wdata
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  logic [31:0]       bmem [BMEM_WORDS];
  logic [31:0]       rdword, host_word, reg_q;
  logic              win_q, armed, done;
  logic [SAW-1:0]    src_q, rp;
  logic [DST_AW-1:0] dst_q, wp;
  logic [CW-1:0]     cnt_q, left;
  st_t               st;

  wire             busy    = (st != S_IDLE);
  wire             in_win  = host_addr[HAW-1];
  wire [SAW-1:0]   win_idx = host_addr[SAW+1:2];
  wire [HAW-2:0]   off     = host_addr[HAW-2:0];
  wire             wr_ctrl = host_wr && !in_win && off == (HAW-1)'(0);
  wire             cfg_we  = host_wr && !in_win && !busy;
  wire             start_req = !busy && ((wr_ctrl && host_wdata[31]) || (pwr_up && armed));

  always_ff @(posedge clk) begin
    if (host_wr && in_win) bmem[win_idx] <= host_wdata;
    if (host_rd) host_word <= bmem[win_idx];
    rdword <= bmem[rp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      armed <= 1'b0;
      done  <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      rp    <= '0;
      wp    <= '0;
      left  <= '0;
    end else begin
      if (wr_ctrl) armed <= host_wdata[30];
      if (cfg_we && off == (HAW-1)'(4))  src_q <= host_wdata[SAW-1:0];
      if (cfg_we && off == (HAW-1)'(8))  dst_q <= host_wdata[DST_AW-1:0];
      if (cfg_we && off == (HAW-1)'(12)) cnt_q <= host_wdata[CW-1:0];
      case (st)
        S_IDLE: if (start_req) begin
          rp   <= src_q;
          wp   <= dst_q;
          left <= cnt_q;
          done <= (cnt_q == '0);
          st   <= (cnt_q == '0) ? S_IDLE : S_RD;
        end
        S_RD: st <= S_WR;
        S_WR: begin
          rp   <= rp + 1'b1;
          wp   <= wp + 1'b1;
          left <= left - 1'b1;
          if (left == CW'(1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      reg_q <= '0;
    end else if (host_rd) begin
      win_q <= in_win;
      reg_q <= '0;
      if (!in_win) begin
        case (off)
          (HAW-1)'(0):  reg_q <= {busy, armed, 30'd0};
          (HAW-1)'(4):  reg_q <= 32'(src_q);
          (HAW-1)'(8):  reg_q <= 32'(dst_q);
          (HAW-1)'(12): reg_q <= 32'(cnt_q);
          (HAW-1)'(16): reg_q <= {31'd0, done};
          default:      reg_q <= '0;
        endcase
      end
    end
  end

  assign host_rdata = win_q ? host_word : reg_q;
  assign imem_we    = (st == S_WR);
  assign imem_addr  = wp;
  assign imem_wdata = rdword;

  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |=> !imem_we);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_we && $past(imem_we, 2)) |-> imem_addr == $past(imem_addr, 2) + 1'b1);

  a_r6_done_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  a_r4_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && left == CW'(1)) |=> (!busy && done));

  a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && cnt_q == '0) |=> (!busy && done));

  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(cnt_q) && $stable(src_q) && $stable(dst_q)));

  a_r9_idle_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up && !armed && !busy && !host_wr) |=> !busy);

endmodule

// File: tb/boot_copy_engine_test.sv
module boot_copy_engine_test;
  localparam int DAW = 12;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, pwr_up = 0;
  logic [10:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic imem_we;
  logic [DAW-1:0] imem_addr;
  logic [31:0] imem_wdata;

  always #2 clk = ~clk;

  boot_copy_engine uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pwr_up(pwr_up), .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata)
  );

  int errors = 0, checks = 0, nwrites = 0, exp_total = 0, cyc = 0, last_cyc = 0;
  bit done_flag = 0;
  logic [31:0] bimg [256];
  logic [31:0] imem [1 << DAW];
  logic [DAW+32:0] exp_q [$];

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && imem_we) begin
      nwrites++;
      imem[imem_addr] = imem_wdata;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5: unexpected write addr %h data %h expected none", imem_addr, imem_wdata);
      end else begin
        logic [DAW+32:0] e;
        e = exp_q.pop_front();
        if (e[DAW+31:32] !== imem_addr || e[31:0] !== imem_wdata) begin
          errors++;
          $display("FAIL R5: write %h/%h expected %h/%h", imem_addr, imem_wdata, e[DAW+31:32], e[31:0]);
        end
        if (!e[DAW+32]) check("R5 write spacing", cyc - last_cyc, 2);
      end
      last_cyc = cyc;
    end
  end

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    host_rd = 1; host_addr = a;
    @(negedge clk);
    host_rd = 0;
    d = host_rdata;
  endtask

  task automatic push_copy(input int src, input int dst, input int n);
    for (int k = 0; k < n; k++) begin
      logic [DAW-1:0] da;
      da = DAW'(dst + k);
      exp_q.push_back({(k == 0), da, bimg[(src + k) % 256]});
    end
    exp_total += n;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(11'h000, v);
      if (!v[31]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_pwr();
    pwr_up = 1;
    @(negedge clk);
    pwr_up = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(11'h000, v); check("R1 ctrl after reset", v, 0);
    rd(11'h010, v); check("R1 status after reset", v, 0);
    check("R1 no writes after reset", nwrites, 0);

    for (int i = 0; i < 256; i++) begin
      bimg[i] = 32'h5A00_0000 ^ (i * 32'h0103_0507) ^ (i << 20);
      wr(11'(11'h400 + 4 * i), bimg[i]);
    end
    rd(11'h400, v); check("R2 window word 0", v, bimg[0]);
    rd(11'h7FC, v); check("R2 window word 255", v, bimg[255]);
    rd(11'h500, v); check("R2 window word 64", v, bimg[64]);

    wr(11'h004, 32'hFFFF_FFFF); rd(11'h004, v); check("R3 src mask", v, 32'h0FF);
    wr(11'h008, 32'hFFFF_FFFF); rd(11'h008, v); check("R3 dst mask", v, 32'hFFF);
    wr(11'h00C, 32'hFFFF_FFFF); rd(11'h00C, v); check("R3 count mask", v, 32'h1FF);
    rd(11'h014, v); check("R3 undefined 0x014", v, 0);
    rd(11'h3FC, v); check("R3 undefined 0x3FC", v, 0);

    wr(11'h004, 10); wr(11'h008, 32'h100); wr(11'h00C, 5);
    push_copy(10, 32'h100, 5);
    wr(11'h000, 32'h8000_0000);
    rd(11'h000, v); check("R4 start bit reads 1 while busy", v, 32'h8000_0000);
    wait_idle();
    rd(11'h000, v); check("R4 start bit clears", v, 0);
    rd(11'h010, v); check("R6 done after copy", v, 1);
    check("R5 queue drained", exp_q.size(), 0);

    wr(11'h004, 250); wr(11'h008, 32'h200); wr(11'h00C, 10);
    push_copy(250, 32'h200, 10);
    wr(11'h000, 32'h8000_0000);
    rd(11'h010, v); check("R6 done cleared at start", v, 0);
    wait_idle();
    check("R5 wrap copy drained", exp_q.size(), 0);
    check("R5 write total", nwrites, exp_total);

    wr(11'h00C, 0);
    wr(11'h000, 32'h8000_0000);
    rd(11'h000, v); check("R7 zero count not busy", v, 0);
    rd(11'h010, v); check("R7 zero count done", v, 1);
    repeat (6) @(negedge clk);
    check("R7 zero count no writes", nwrites, exp_total);

    wr(11'h004, 20); wr(11'h008, 32'h300); wr(11'h00C, 6);
    push_copy(20, 32'h300, 6);
    wr(11'h000, 32'h8000_0000);
    wr(11'h00C, 1); wr(11'h004, 0); wr(11'h008, 0);
    wr(11'h000, 32'h8000_0000);
    wait_idle();
    rd(11'h00C, v); check("R8 count kept", v, 6);
    rd(11'h004, v); check("R8 src kept", v, 20);
    rd(11'h008, v); check("R8 dst kept", v, 32'h300);
    check("R8 original copy only", nwrites, exp_total);

    pulse_pwr();
    repeat (20) @(negedge clk);
    check("R9 unarmed power-up no writes", nwrites, exp_total);
    rd(11'h000, v); check("R9 unarmed stays idle", v, 0);
    wr(11'h000, 32'h4000_0000);
    rd(11'h000, v); check("R9 arm bit readback", v, 32'h4000_0000);
    push_copy(20, 32'h300, 6);
    pulse_pwr();
    wait_idle();
    check("R9 armed power-up copy", nwrites, exp_total);
    rd(11'h010, v); check("R9 done after auto copy", v, 1);

    push_copy(20, 32'h300, 6);
    pulse_pwr();
    wait_idle();
    check("R10 repeated auto copy", nwrites, exp_total);
    check("R10 queue drained", exp_q.size(), 0);
    rd(11'h450, v); check("R10 image kept", v, bimg[20]);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule